// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap and Interrupt Entry

This block is the main control state machine for a small multicycle processor that executes register-register ALU operations, word loads, word stores, equal-branches and direct jumps. Each instruction takes several clock cycles. The sequencer walks through fetch, decode, execute, memory and write-back steps. In every step it drives the full set of datapath select and write-enable signals as a pure function of its current state.

Two extra states handle exceptions. A trap state is entered from decode when the opcode has no defined path, and from the ALU execute step when the ALU reports overflow. The trap state winds the program counter back by four through the ALU and saves it as the exception return address, so the return address points at the offending instruction. An interrupt state is entered at the end of any instruction while an interrupt request is pending. It saves the already-advanced program counter. Both states select the fixed handler vector on the PC source mux, write the cause and status registers, and drive an exception code.

The datapath, the handler address constant and the coprocessor registers are outside the block. The datapath decodes `pc_src` = 3 as the handler vector.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-high reset places the sequencer in state 0 (fetch). The current state is reported on `state_o` as its number 0 to 11.
- R2: State 0 drives `mem_rd`, `ir_wr` and `pc_wr`, with `srcb_sel`=1 and all other fields 0. It always moves to state 1.
- R3: State 1 drives only `srcb_sel`=3. It then moves to state 2 for opcodes 0x23 (load) and 0x2B (store), state 6 for opcode 0x00 (ALU op), state 8 for 0x04 (branch) and state 9 for 0x02 (jump).
- R4: State 2 drives `srca_sel`=1 and `srcb_sel`=2, and moves to 3 for a load or 5 for a store. State 3 drives `mem_rd` and `addr_sel` and moves to 4. State 5 drives `mem_wr` and `addr_sel`.
- R5: State 4 drives `reg_wr` and `wb_sel`=1 with `dst_sel`=0.
- R6: State 6 drives `srca_sel`=1 and `alu_op`=2. It moves to state 7 when `alu_ovf` is 0 and to state 10 when `alu_ovf` is 1. State 7 drives `reg_wr` and `dst_sel`=1 with `wb_sel`=0.
- R7: State 8 drives `srca_sel`=1, `alu_op`=1, `pc_src`=1 and `pc_wr_cond`. State 9 drives `pc_src`=2 and `pc_wr`.
- R8: Any opcode other than 0x00, 0x02, 0x04, 0x23 and 0x2B moves from state 1 to state 10.
- R9: State 10 drives `cause_wr`, `epc_wr`, `epc_src`=1, `pc_wr`, `pc_src`=3, `srcb_sel`=1 and `alu_op`=1. `exc_code` is 10 if the trap came from decode and 12 if it came from overflow.
- R10: State 11 drives `cause_wr`, `epc_wr`, `pc_wr` and `pc_src`=3 with `epc_src`=0 and `exc_code`=0.
- R11: States 4, 5, 7, 8 and 9 move to state 11 when `irq_pend` is 1 and to state 0 otherwise. States 10 and 11 always move to state 0. `irq_pend` has no effect in any other state.
- R12: Every output a state does not name is 0. `exc_code` is 0 outside state 10, and `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| irq_pend | input | 1 | Pending, unmasked interrupt request |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU zero flag is set |
| reg_wr | output | 1 | Register file write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| wb_sel | output | 1 | Write-back data: 0 ALU result, 1 memory data |
| dst_sel | output | 1 | Destination field: 0 rt, 1 rd |
| srca_sel | output | 1 | ALU A: 0 PC, 1 register A |
| srcb_sel | output | 2 | ALU B: 0 reg B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 function field |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALU result reg, 2 jump target, 3 handler vector |
| epc_wr | output | 1 | Exception return address write |
| epc_src | output | 1 | Return address source: 1 ALU (PC-4), 0 PC |
| cause_wr | output | 1 | Cause and status register write |
| exc_code | output | 5 | Exception code for the cause register |
| state_o | output | 4 | Current state number |

## Verification
The bench builds the block with its default 6-bit opcode and 5-bit exception code. At that size it is practical to step every one of the 64 opcodes, under each combination of the overflow flag and the interrupt request, through a complete instruction from fetch back to fetch. This reaches every state, every decode successor, both trap causes and both end-of-instruction exits. The bench compares the full output bundle and the state number in every cycle against a model written from the requirements. A reset applied mid-instruction is also covered.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;
    localparam int CODE_W  = 5;

    localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    localparam int CODE_UNDEF = 10;
    localparam int CODE_OVFL  = 12;
    localparam int CODE_IRQ   = 0;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_MEMRD   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_MEMWR   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_ALUWB   = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9,
        ST_TRAP    = 4'd10,
        ST_IRQ     = 4'd11
    } state_t;

    typedef enum logic [2:0] {
        IC_ALU,
        IC_LOAD,
        IC_STORE,
        IC_BRANCH,
        IC_JUMP,
        IC_UNDEF
    } iclass_t;

    typedef enum logic [1:0] {
        SB_REGB  = 2'd0,
        SB_FOUR  = 2'd1,
        SB_IMM   = 2'd2,
        SB_IMMSH = 2'd3
    } srcb_t;

    typedef enum logic [1:0] {
        AO_ADD  = 2'd0,
        AO_SUB  = 2'd1,
        AO_FUNC = 2'd2
    } aluop_t;

    typedef enum logic [1:0] {
        PS_ALU    = 2'd0,
        PS_ALUREG = 2'd1,
        PS_JUMP   = 2'd2,
        PS_VECTOR = 2'd3
    } pcsrc_t;

    typedef struct packed {
        logic   mem_rd;
        logic   mem_wr;
        logic   ir_wr;
        logic   pc_wr;
        logic   pc_wr_cond;
        logic   reg_wr;
        logic   addr_sel;
        logic   wb_sel;
        logic   dst_sel;
        logic   srca_sel;
        srcb_t  srcb_sel;
        aluop_t alu_op;
        pcsrc_t pc_src;
        logic   epc_wr;
        logic   epc_src;
        logic   cause_wr;
    } ctrl_t;

    function automatic ctrl_t ctrl_quiet();
        ctrl_t c;
        c = '0;
        return c;
    endfunction

    // Last step of every non-exception instruction path.
    function automatic logic is_retire(state_t s);
        return (s == ST_LDWB) || (s == ST_MEMWR) || (s == ST_ALUWB) ||
               (s == ST_BRANCH) || (s == ST_JUMP);
    endfunction

endpackage

// File: rtl/mcyc_opclass.sv
module mcyc_opclass
    import mcyc_pkg::*;
#(
    parameter int                OP_W      = OPC_W,
    parameter logic [OP_W-1:0]   OP_ALU    = OPC_ALU,
    parameter logic [OP_W-1:0]   OP_JUMP   = OPC_JUMP,
    parameter logic [OP_W-1:0]   OP_BRANCH = OPC_BRANCH,
    parameter logic [OP_W-1:0]   OP_LOAD   = OPC_LOAD,
    parameter logic [OP_W-1:0]   OP_STORE  = OPC_STORE
) (
    input  logic [OP_W-1:0] opcode,
    output iclass_t         iclass
);

    always_comb begin
        if (opcode == OP_ALU)         iclass = IC_ALU;
        else if (opcode == OP_LOAD)   iclass = IC_LOAD;
        else if (opcode == OP_STORE)  iclass = IC_STORE;
        else if (opcode == OP_BRANCH) iclass = IC_BRANCH;
        else if (opcode == OP_JUMP)   iclass = IC_JUMP;
        else                          iclass = IC_UNDEF;
    end

endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
    import mcyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_t iclass,
    input  logic    alu_ovf,
    input  logic    irq_pend,
    output state_t  state,
    output logic    trap_from_ovf
);

    state_t nxt;

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass)
                    IC_LOAD, IC_STORE: nxt = ST_ADDR;
                    IC_ALU:            nxt = ST_EXEC;
                    IC_BRANCH:         nxt = ST_BRANCH;
                    IC_JUMP:           nxt = ST_JUMP;
                    default:           nxt = ST_TRAP;
                endcase
            end
            ST_ADDR:   nxt = (iclass == IC_STORE) ? ST_MEMWR : ST_MEMRD;
            ST_MEMRD:  nxt = ST_LDWB;
            ST_EXEC:   nxt = alu_ovf ? ST_TRAP : ST_ALUWB;
            ST_LDWB, ST_MEMWR, ST_ALUWB, ST_BRANCH, ST_JUMP:
                       nxt = irq_pend ? ST_IRQ : ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_FETCH;
            trap_from_ovf <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_TRAP) begin
                trap_from_ovf <= (state == ST_EXEC);
            end
        end
    end

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_pkg::*;
#(
    parameter int CW        = CODE_W,
    parameter int C_UNDEF   = CODE_UNDEF,
    parameter int C_OVFL    = CODE_OVFL,
    parameter int C_IRQ     = CODE_IRQ
) (
    input  state_t        state,
    input  logic          trap_from_ovf,
    output ctrl_t         ctrl,
    output logic [CW-1:0] exc_code
);

    always_comb begin
        ctrl     = ctrl_quiet();
        exc_code = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.ir_wr    = 1'b1;
                ctrl.srcb_sel = SB_FOUR;
                ctrl.alu_op   = AO_ADD;
                ctrl.pc_src   = PS_ALU;
                ctrl.pc_wr    = 1'b1;
            end
            ST_DECODE: begin
                ctrl.srcb_sel = SB_IMMSH;
            end
            ST_ADDR: begin
                ctrl.srca_sel = 1'b1;
                ctrl.srcb_sel = SB_IMM;
            end
            ST_MEMRD: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.wb_sel   = 1'b1;
            end
            ST_MEMWR: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctrl.srca_sel = 1'b1;
                ctrl.alu_op   = AO_FUNC;
            end
            ST_ALUWB: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.dst_sel  = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.srca_sel   = 1'b1;
                ctrl.alu_op     = AO_SUB;
                ctrl.pc_src     = PS_ALUREG;
                ctrl.pc_wr_cond = 1'b1;
            end
            ST_JUMP: begin
                ctrl.pc_src = PS_JUMP;
                ctrl.pc_wr  = 1'b1;
            end
            ST_TRAP: begin
                // ALU computes PC - 4 so the saved address is the faulting one.
                ctrl.cause_wr = 1'b1;
                ctrl.srcb_sel = SB_FOUR;
                ctrl.alu_op   = AO_SUB;
                ctrl.epc_wr   = 1'b1;
                ctrl.epc_src  = 1'b1;
                ctrl.pc_src   = PS_VECTOR;
                ctrl.pc_wr    = 1'b1;
                exc_code      = trap_from_ovf ? CW'(C_OVFL) : CW'(C_UNDEF);
            end
            ST_IRQ: begin
                ctrl.cause_wr = 1'b1;
                ctrl.epc_wr   = 1'b1;
                ctrl.epc_src  = 1'b0;
                ctrl.pc_src   = PS_VECTOR;
                ctrl.pc_wr    = 1'b1;
                exc_code      = CW'(C_IRQ);
            end
            default: begin
                ctrl     = ctrl_quiet();
                exc_code = '0;
            end
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int OP_W = OPC_W,
    parameter int CW   = CODE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    input  logic            irq_pend,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            reg_wr,
    output logic            addr_sel,
    output logic            wb_sel,
    output logic            dst_sel,
    output logic            srca_sel,
    output logic [1:0]      srcb_sel,
    output logic [1:0]      alu_op,
    output logic [1:0]      pc_src,
    output logic            epc_wr,
    output logic            epc_src,
    output logic            cause_wr,
    output logic [CW-1:0]   exc_code,
    output logic [3:0]      state_o
);

    localparam int OPC_TOP = OP_W - 1;

    iclass_t iclass;
    state_t  state;
    logic    trap_from_ovf;
    ctrl_t   ctrl;

    mcyc_opclass #(
        .OP_W      (OP_W),
        .OP_ALU    (OP_W'(OPC_ALU)),
        .OP_JUMP   (OP_W'(OPC_JUMP)),
        .OP_BRANCH (OP_W'(OPC_BRANCH)),
        .OP_LOAD   (OP_W'(OPC_LOAD)),
        .OP_STORE  (OP_W'(OPC_STORE))
    ) u_opclass (
        .opcode (opcode[OPC_TOP:0]),
        .iclass (iclass)
    );

    mcyc_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .iclass        (iclass),
        .alu_ovf       (alu_ovf),
        .irq_pend      (irq_pend),
        .state         (state),
        .trap_from_ovf (trap_from_ovf)
    );

    mcyc_decode #(
        .CW (CW)
    ) u_decode (
        .state         (state),
        .trap_from_ovf (trap_from_ovf),
        .ctrl          (ctrl),
        .exc_code      (exc_code)
    );

    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign ir_wr      = ctrl.ir_wr;
    assign pc_wr      = ctrl.pc_wr;
    assign pc_wr_cond = ctrl.pc_wr_cond;
    assign reg_wr     = ctrl.reg_wr;
    assign addr_sel   = ctrl.addr_sel;
    assign wb_sel     = ctrl.wb_sel;
    assign dst_sel    = ctrl.dst_sel;
    assign srca_sel   = ctrl.srca_sel;
    assign srcb_sel   = ctrl.srcb_sel;
    assign alu_op     = ctrl.alu_op;
    assign pc_src     = ctrl.pc_src;
    assign epc_wr     = ctrl.epc_wr;
    assign epc_src    = ctrl.epc_src;
    assign cause_wr   = ctrl.cause_wr;
    assign state_o    = state;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          alu_ovf,
    input logic          irq_pend,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          pc_wr,
    input logic          cause_wr,
    input logic          epc_wr,
    input logic [CW-1:0] exc_code,
    input logic [3:0]    state_o
);

    logic at_retire;
    assign at_retire = (state_o == 4'd4) || (state_o == 4'd5) || (state_o == 4'd7) ||
                       (state_o == 4'd8) || (state_o == 4'd9);

    // R1
    a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_o == 4'd0);

    // R2
    a_r2_fetch_decode: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd0 |=> state_o == 4'd1);

    // R6
    a_r6_ovf_trap: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd6 && alu_ovf) |=> state_o == 4'd10);

    // R11
    a_r11_irq_entry: assert property (@(posedge clk) disable iff (rst)
        (at_retire && irq_pend) |=> state_o == 4'd11);

    a_r11_exc_return: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd10 || state_o == 4'd11) |=> state_o == 4'd0);

    // R9
    a_r9_trap_code: assert property (@(posedge clk) disable iff (rst)
        state_o == 4'd10 |-> (exc_code == CW'(10) || exc_code == CW'(12)));

    // R10
    a_r10_save_set: assert property (@(posedge clk) disable iff (rst)
        epc_wr |-> (pc_wr && cause_wr));

    // R12
    a_r12_code_quiet: assert property (@(posedge clk) disable iff (rst)
        state_o != 4'd10 |-> exc_code == '0);

    a_r12_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .alu_ovf  (alu_ovf),
    .irq_pend (irq_pend),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .pc_wr    (pc_wr),
    .cause_wr (cause_wr),
    .epc_wr   (epc_wr),
    .exc_code (exc_code),
    .state_o  (state_o)
);

// File: tb/mcyc_ctrl_test.sv
`timescale 1ns/100ps
module mcyc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic       alu_ovf = 1'b0;
    logic       irq_pend = 1'b0;
    logic       mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr;
    logic       addr_sel, wb_sel, dst_sel, srca_sel;
    logic [1:0] srcb_sel, alu_op, pc_src;
    logic       epc_wr, epc_src, cause_wr;
    logic [4:0] exc_code;
    logic [3:0] state_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    mcyc_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .irq_pend(irq_pend),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .reg_wr(reg_wr), .addr_sel(addr_sel),
        .wb_sel(wb_sel), .dst_sel(dst_sel), .srca_sel(srca_sel),
        .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_src(pc_src),
        .epc_wr(epc_wr), .epc_src(epc_src), .cause_wr(cause_wr),
        .exc_code(exc_code), .state_o(state_o)
    );

    // Bundle order: rd wr ir pcw pcwc rw addr wb dst srca srcb alu pcsrc epcw epcs cause code
    function automatic logic [23:0] actual_bundle();
        return {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, addr_sel, wb_sel,
                dst_sel, srca_sel, srcb_sel, alu_op, pc_src, epc_wr, epc_src,
                cause_wr, exc_code};
    endfunction

    function automatic logic [23:0] mk(logic rd, logic wr, logic ir, logic pcw, logic pcwc,
                                       logic rw, logic ad, logic wb, logic ds, logic sa,
                                       logic [1:0] sb, logic [1:0] ao, logic [1:0] ps,
                                       logic ew, logic es, logic cw, logic [4:0] cd);
        return {rd, wr, ir, pcw, pcwc, rw, ad, wb, ds, sa, sb, ao, ps, ew, es, cw, cd};
    endfunction

    function automatic logic [23:0] exp_bundle(logic [3:0] s, logic ovf_cause);
        case (s)
            4'd0:  return mk(1,0,1,1,0,0,0,0,0,0,2'd1,2'd0,2'd0,0,0,0,5'd0);
            4'd1:  return mk(0,0,0,0,0,0,0,0,0,0,2'd3,2'd0,2'd0,0,0,0,5'd0);
            4'd2:  return mk(0,0,0,0,0,0,0,0,0,1,2'd2,2'd0,2'd0,0,0,0,5'd0);
            4'd3:  return mk(1,0,0,0,0,0,1,0,0,0,2'd0,2'd0,2'd0,0,0,0,5'd0);
            4'd4:  return mk(0,0,0,0,0,1,0,1,0,0,2'd0,2'd0,2'd0,0,0,0,5'd0);
            4'd5:  return mk(0,1,0,0,0,0,1,0,0,0,2'd0,2'd0,2'd0,0,0,0,5'd0);
            4'd6:  return mk(0,0,0,0,0,0,0,0,0,1,2'd0,2'd2,2'd0,0,0,0,5'd0);
            4'd7:  return mk(0,0,0,0,0,1,0,0,1,0,2'd0,2'd0,2'd0,0,0,0,5'd0);
            4'd8:  return mk(0,0,0,0,1,0,0,0,0,1,2'd0,2'd1,2'd1,0,0,0,5'd0);
            4'd9:  return mk(0,0,0,1,0,0,0,0,0,0,2'd0,2'd0,2'd2,0,0,0,5'd0);
            4'd10: return mk(0,0,0,1,0,0,0,0,0,0,2'd1,2'd1,2'd3,1,1,1,
                             ovf_cause ? 5'd12 : 5'd10);
            4'd11: return mk(0,0,0,1,0,0,0,0,0,0,2'd0,2'd0,2'd3,1,0,1,5'd0);
            default: return '0;
        endcase
    endfunction

    function automatic logic [3:0] exp_next(logic [3:0] s, logic [5:0] op, logic ovf, logic irq);
        case (s)
            4'd0: return 4'd1;
            4'd1: begin
                if (op == 6'h23 || op == 6'h2B) return 4'd2;
                if (op == 6'h00) return 4'd6;
                if (op == 6'h04) return 4'd8;
                if (op == 6'h02) return 4'd9;
                return 4'd10;
            end
            4'd2: return (op == 6'h2B) ? 4'd5 : 4'd3;
            4'd3: return 4'd4;
            4'd6: return ovf ? 4'd10 : 4'd7;
            4'd4, 4'd5, 4'd7, 4'd8, 4'd9: return irq ? 4'd11 : 4'd0;
            default: return 4'd0;
        endcase
    endfunction

    function automatic string out_tag(logic [3:0] s);
        case (s)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3, 4'd5: return "R4";
            4'd4: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic string step_tag(logic [3:0] prev, logic [5:0] op);
        case (prev)
            4'd0: return "R2";
            4'd1: begin
                if (op == 6'h00 || op == 6'h02 || op == 6'h04 || op == 6'h23 || op == 6'h2B)
                    return "R3";
                return "R8";
            end
            4'd2, 4'd3: return "R4";
            4'd6: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check_state(string tag, logic [3:0] exp);
        total++;
        if (state_o !== exp) begin
            bad++;
            $display("FAIL %s state actual=%0d expected=%0d", tag, state_o, exp);
        end
    endtask

    task automatic check_out(string tag, logic [23:0] exp);
        total++;
        if (actual_bundle() !== exp) begin
            bad++;
            $display("FAIL %s outputs actual=%h expected=%h (state %0d)", tag,
                     actual_bundle(), exp, state_o);
        end
    endtask

    // Runs one instruction from fetch back to fetch; inputs stay fixed throughout.
    task automatic run_instr(logic [5:0] op, logic ovf, logic irq);
        logic [3:0] cur;
        logic [3:0] prv;
        logic       ovf_cause;
        opcode   = op;
        alu_ovf  = ovf;
        irq_pend = irq;
        cur = 4'd0;
        ovf_cause = 1'b0;
        for (int step = 0; step < 8; step++) begin
            check_state((step == 0) ? "R11" : step_tag(prv, op), cur);
            check_out(out_tag(cur), exp_bundle(cur, ovf_cause));
            if (cur != 4'd10) begin
                total++;
                if (exc_code !== 5'd0) begin
                    bad++;
                    $display("FAIL R12 exc_code actual=%0d expected=0", exc_code);
                end
            end
            prv = cur;
            if (exp_next(cur, op, ovf, irq) == 4'd10) ovf_cause = (cur == 4'd6);
            cur = exp_next(cur, op, ovf, irq);
            @(negedge clk);
            if (cur == 4'd0) break;
        end
        check_state("R11", 4'd0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R1", 4'd0);
        check_out("R1", exp_bundle(4'd0, 1'b0));
        rst = 1'b0;

        for (int o = 0; o < 64; o++) begin
            for (int v = 0; v < 2; v++) begin
                for (int q = 0; q < 2; q++) begin
                    run_instr(6'(o), v[0], q[0]);
                end
            end
        end

        // Reset in the middle of an ALU instruction
        opcode = 6'h00; alu_ovf = 1'b0; irq_pend = 1'b0;
        repeat (2) @(negedge clk);
        check_state("R3", 4'd6);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1", 4'd0);
        check_out("R1", exp_bundle(4'd0, 1'b0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule